// File: doc/BRIEF.md
# Shifted-Carrier Multilevel Gate Modulator

This block produces the switch gate commands for a full-bridge inverter in which each leg is a series stack of N switching cells joined by floating capacitors. A single phase counter sweeps a period of 2P clock cycles. From that counter the block derives one triangular carrier per cell, spread evenly over the period. Each carrier is compared with a latched reference level, and the result drives a complementary pair of gate lines through a dead-time stage.

The reference is a signed sample from an external sine source. Leg A uses it as given. Leg B uses its negation, which places the second leg half a cycle away. The reference is taken only at the start of each carrier period, so a change of reference never cuts a pulse short partway through a period. The block has no feedback path: capacitor balance comes from the equal duty cycles and the even carrier spacing. Gate outputs are registered. Taking reset or dropping the enable input turns every gate off and restarts the sweep.

Top module: `scm_gate_modulator`

## Requirements
- R1: When `rst` is high or `en` is low, all gate outputs are 0 on the next clock, and the phase counter and latched levels go to 0.
- R2: While enabled, the phase counter counts 0, 1, …, 2P−1 and then returns to 0, where P = `period` (P ≥ 1). Cell k (k = 0…N−1) has phase q = (count + k·floor(2P/N)) mod 2P and carrier value q when q < P, else 2P−q.
- R3: A reference r (two's complement, REF_W bits) maps to the level m = ((r + 2^(REF_W−1))·P) >> REF_W, which lies in 0…P−1.
- R4: Leg A uses r. Leg B uses −r, and the most negative code maps to the most positive code.
- R5: Both legs' levels are latched only on an enabled clock at which the phase counter is 0. A reference change at any other time has no effect until the next such clock.
- R6: The upper command of a cell is 1 when the leg level is greater than that cell's carrier, and 0 otherwise. The lower command is its inverse. Commands are formed from the phase count and levels held before a clock edge and act on the gates at that edge.
- R7: A gate whose command is 0 is low after the next clock. A gate whose command turns to 1 goes high on the (D+1)-th consecutive clock with the command at 1, where D = `dead`. A command pulse shorter than this never turns the gate on.
- R8: The upper and lower gates of a cell are never high in the same cycle.
- R9: With a constant reference held over a full period, every cell of a leg has its upper gate high for the same number of cycles per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces gates off and restarts the sweep |
| ref_in | input | REF_W | Signed reference sample |
| period | input | CNT_W | Carrier half-period P in clocks |
| dead | input | DT_W | Turn-on delay D in clocks |
| gate_hi_a | output | N_CELLS | Leg A upper gates, one bit per cell |
| gate_lo_a | output | N_CELLS | Leg A lower gates |
| gate_hi_b | output | N_CELLS | Leg B upper gates |
| gate_lo_b | output | N_CELLS | Leg B lower gates |

## Verification
The bench builds the block with N_CELLS = 4, an 8-bit reference, a 6-bit period and a 4-bit dead-time count. The narrow reference lets every one of the 256 codes, including the most negative code that must saturate on negation, be applied in each configuration. It changes the reference on a 7-cycle stride that falls out of step with the carrier period, so most changes land mid-period. The periods used include ones where 2P divides evenly by four and ones where it does not, and the dead times include zero and values longer than some command pulses, so the carrier offsets and the swallowed-pulse case are both reached.

// File: rtl/scm_pkg.sv
package scm_pkg;
  // Bridge legs driven by the modulator
  localparam int LEGS = 2;
  typedef enum logic {LEG_A = 1'b0, LEG_B = 1'b1} leg_e;
  // Position of a gate within a cell's pair
  typedef enum logic {SIDE_HI = 1'b0, SIDE_LO = 1'b1} side_e;
endpackage

// File: rtl/scm_carrier_bank.sv
module scm_carrier_bank #(
  parameter int N_CELLS = 5,
  parameter int CNT_W   = 16,
  localparam int PH_W   = CNT_W + 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            en,
  input  logic [CNT_W-1:0]                period,
  output logic [PH_W-1:0]                 phase_q,
  output logic [N_CELLS-1:0][CNT_W-1:0]   carrier
);
  logic [PH_W-1:0] span;
  logic [PH_W-1:0] step;

  assign span = {period, 1'b0};
  assign step = span / PH_W'(N_CELLS);

  // Shared sweep over one full carrier period
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase_q <= '0;
    end else if (phase_q >= span - PH_W'(1)) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + PH_W'(1);
    end
  end

  // One folded triangle per cell, each offset by a fixed share of the period
  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    logic [PH_W-1:0] offset;
    logic [PH_W:0]   sum;
    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] tri_v;

    assign offset = PH_W'(k) * step;
    assign sum    = {1'b0, phase_q} + {1'b0, offset};
    assign ph     = (sum >= {1'b0, span}) ? PH_W'(sum - {1'b0, span}) : sum[PH_W-1:0];
    assign tri_v  = (ph < {1'b0, period}) ? ph : (span - ph);
    assign carrier[k] = tri_v[CNT_W-1:0];
  end
endmodule

// File: rtl/scm_ref_sampler.sv
module scm_ref_sampler #(
  parameter int REF_W = 16,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    sample,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [CNT_W-1:0]        period,
  output logic [CNT_W-1:0]        map_a,
  output logic [CNT_W-1:0]        map_b
);
  localparam int PROD_W = REF_W + CNT_W;
  localparam logic [REF_W-1:0] MOST_NEG = {1'b1, {(REF_W-1){1'b0}}};
  localparam logic [REF_W-1:0] MOST_POS = {1'b0, {(REF_W-1){1'b1}}};

  logic [REF_W-1:0] ref_neg;
  logic [CNT_W-1:0] lvl_a;
  logic [CNT_W-1:0] lvl_b;

  // Offset-binary scaling of a signed sample onto 0..P-1
  function automatic logic [CNT_W-1:0] scale(input logic [REF_W-1:0] r,
                                             input logic [CNT_W-1:0] p);
    logic [REF_W-1:0]  u;
    logic [PROD_W-1:0] prod;
    u    = {~r[REF_W-1], r[REF_W-2:0]};
    prod = {{CNT_W{1'b0}}, u} * {{REF_W{1'b0}}, p};
    return prod[PROD_W-1:REF_W];
  endfunction

  assign ref_neg = (ref_in == MOST_NEG) ? MOST_POS : (~ref_in + REF_W'(1));
  assign lvl_a   = scale(ref_in, period);
  assign lvl_b   = scale(ref_neg, period);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      map_a <= '0;
      map_b <= '0;
    end else if (sample) begin
      map_a <= lvl_a;
      map_b <= lvl_b;
    end
  end
endmodule

// File: rtl/scm_dead_gate.sv
module scm_dead_gate #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            cmd,
  input  logic [DT_W-1:0] dead,
  output logic            gate
);
  logic [DT_W-1:0] wait_q;

  // Turn-off is immediate; turn-on waits until the command has held for dead+1 clocks
  always_ff @(posedge clk) begin
    if (rst || !en || !cmd) begin
      gate   <= 1'b0;
      wait_q <= '0;
    end else if (!gate) begin
      if (wait_q == dead) begin
        gate <= 1'b1;
      end else begin
        wait_q <= wait_q + DT_W'(1);
      end
    end
  end
endmodule

// File: rtl/scm_gate_modulator.sv
module scm_gate_modulator #(
  parameter int N_CELLS = 5,
  parameter int CNT_W   = 16,
  parameter int REF_W   = 16,
  parameter int DT_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [CNT_W-1:0]        period,
  input  logic [DT_W-1:0]         dead,
  output logic [N_CELLS-1:0]      gate_hi_a,
  output logic [N_CELLS-1:0]      gate_lo_a,
  output logic [N_CELLS-1:0]      gate_hi_b,
  output logic [N_CELLS-1:0]      gate_lo_b
);
  import scm_pkg::*;

  localparam int PH_W = CNT_W + 1;

  logic [PH_W-1:0]                    phase_q;
  logic [N_CELLS-1:0][CNT_W-1:0]      carrier;
  logic [CNT_W-1:0]                   map_a;
  logic [CNT_W-1:0]                   map_b;
  logic [LEGS-1:0][CNT_W-1:0]         leg_map;
  logic [LEGS-1:0][1:0][N_CELLS-1:0]  gates;

  scm_carrier_bank #(.N_CELLS(N_CELLS), .CNT_W(CNT_W)) u_carriers (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .period  (period),
    .phase_q (phase_q),
    .carrier (carrier)
  );

  scm_ref_sampler #(.REF_W(REF_W), .CNT_W(CNT_W)) u_sampler (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .sample (phase_q == '0),
    .ref_in (ref_in),
    .period (period),
    .map_a  (map_a),
    .map_b  (map_b)
  );

  assign leg_map[LEG_A] = map_a;
  assign leg_map[LEG_B] = map_b;

  for (genvar l = 0; l < LEGS; l++) begin : g_leg
    for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
      logic cmd_hi;
      assign cmd_hi = (leg_map[l] > carrier[k]);

      scm_dead_gate #(.DT_W(DT_W)) u_hi (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .cmd  (cmd_hi),
        .dead (dead),
        .gate (gates[l][SIDE_HI][k])
      );

      scm_dead_gate #(.DT_W(DT_W)) u_lo (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .cmd  (!cmd_hi),
        .dead (dead),
        .gate (gates[l][SIDE_LO][k])
      );
    end
  end

  assign gate_hi_a = gates[LEG_A][SIDE_HI];
  assign gate_lo_a = gates[LEG_A][SIDE_LO];
  assign gate_hi_b = gates[LEG_B][SIDE_HI];
  assign gate_lo_b = gates[LEG_B][SIDE_LO];
endmodule

// File: rtl/scm_gate_checker.sv
module scm_gate_checker #(
  parameter int N_CELLS = 5,
  parameter int CNT_W   = 16,
  parameter int DT_W    = 8,
  localparam int PH_W   = CNT_W + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic [CNT_W-1:0]   period,
  input logic [DT_W-1:0]    dead,
  input logic [N_CELLS-1:0] gate_hi_a,
  input logic [N_CELLS-1:0] gate_lo_a,
  input logic [N_CELLS-1:0] gate_hi_b,
  input logic [N_CELLS-1:0] gate_lo_b,
  input logic [PH_W-1:0]    phase,
  input logic [CNT_W-1:0]   map_a,
  input logic [CNT_W-1:0]   map_b
);
  logic [PH_W-1:0] span_m1;
  assign span_m1 = {period, 1'b0} - PH_W'(1);

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    ((gate_hi_a & gate_lo_a) == '0) && ((gate_hi_b & gate_lo_b) == '0));

  p_disabled_low_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gate_hi_a == '0) && (gate_lo_a == '0) && (gate_hi_b == '0) && (gate_lo_b == '0));

  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    (en && phase < span_m1) |=> (phase == PH_W'($past(phase) + PH_W'(1))));

  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (en && phase >= span_m1) |=> (phase == '0));

  p_level_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (en && phase != '0) |=> $stable(map_a) && $stable(map_b));

  for (genvar k = 0; k < N_CELLS; k++) begin : g_gap
    p_gap_hi_a_r7: assert property (@(posedge clk) disable iff (rst)
      (dead != '0 && $stable(dead) && $rose(gate_hi_a[k])) |-> !$past(gate_lo_a[k]));
    p_gap_lo_a_r7: assert property (@(posedge clk) disable iff (rst)
      (dead != '0 && $stable(dead) && $rose(gate_lo_a[k])) |-> !$past(gate_hi_a[k]));
    p_gap_hi_b_r7: assert property (@(posedge clk) disable iff (rst)
      (dead != '0 && $stable(dead) && $rose(gate_hi_b[k])) |-> !$past(gate_lo_b[k]));
    p_gap_lo_b_r7: assert property (@(posedge clk) disable iff (rst)
      (dead != '0 && $stable(dead) && $rose(gate_lo_b[k])) |-> !$past(gate_hi_b[k]));
  end
endmodule

bind scm_gate_modulator scm_gate_checker #(
  .N_CELLS(N_CELLS), .CNT_W(CNT_W), .DT_W(DT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .period    (period),
  .dead      (dead),
  .gate_hi_a (gate_hi_a),
  .gate_lo_a (gate_lo_a),
  .gate_hi_b (gate_hi_b),
  .gate_lo_b (gate_lo_b),
  .phase     (phase_q),
  .map_a     (map_a),
  .map_b     (map_b)
);

// File: tb/scm_gate_modulator_bench.sv
module scm_gate_modulator_bench;
  localparam int N  = 4;
  localparam int CW = 6;
  localparam int RW = 8;
  localparam int DW = 4;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 en  = 1'b0;
  logic signed [RW-1:0] ref_s = '0;
  logic [CW-1:0]        period = CW'(6);
  logic [DW-1:0]        dead = DW'(2);
  logic [N-1:0]         gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  scm_gate_modulator #(.N_CELLS(N), .CNT_W(CW), .REF_W(RW), .DT_W(DW)) u_scm_gate_modulator (
    .clk(clk), .rst(rst), .en(en), .ref_in(ref_s), .period(period), .dead(dead),
    .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a), .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b)
  );

  // Arithmetic model built from the requirements
  int m_ph, m_ma, m_mb;
  bit m_g [2][2][N];   // [leg][0 upper,1 lower][cell]
  int m_dc[2][2][N];

  function automatic int lvl(int r, int p);   // R3
    return ((r + (1 << (RW-1))) * p) >> RW;
  endfunction

  function automatic int negsat(int r);        // R4
    return (r == -(1 << (RW-1))) ? (1 << (RW-1)) - 1 : -r;
  endfunction

  function automatic int carr(int k, int ph, int p);  // R2
    int q;
    q = (ph + k * ((2 * p) / N)) % (2 * p);
    return (q < p) ? q : 2 * p - q;
  endfunction

  always @(posedge clk) begin
    int p;
    p = int'(period);
    if (rst || !en) begin
      m_ph = 0; m_ma = 0; m_mb = 0;
      for (int l = 0; l < 2; l++) for (int s = 0; s < 2; s++) for (int k = 0; k < N; k++) begin
        m_g[l][s][k] = 1'b0; m_dc[l][s][k] = 0;
      end
    end else begin
      for (int l = 0; l < 2; l++) for (int k = 0; k < N; k++) begin
        bit c;
        c = ((l == 0) ? m_ma : m_mb) > carr(k, m_ph, p);   // R6
        for (int s = 0; s < 2; s++) begin
          bit raw;
          raw = (s == 0) ? c : !c;
          if (!raw) begin
            m_g[l][s][k] = 1'b0; m_dc[l][s][k] = 0;          // R7 fall
          end else if (!m_g[l][s][k]) begin
            if (m_dc[l][s][k] == int'(dead)) m_g[l][s][k] = 1'b1;
            else m_dc[l][s][k] = m_dc[l][s][k] + 1;
          end
        end
      end
      if (m_ph == 0) begin                                   // R5
        m_ma = lvl(int'(ref_s), p);
        m_mb = lvl(negsat(int'(ref_s)), p);
      end
      m_ph = (m_ph >= 2 * p - 1) ? 0 : m_ph + 1;
    end
  end

  // Per-cycle comparison of every gate line against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [N-1:0] e_ha, e_la, e_hb, e_lb;
      for (int k = 0; k < N; k++) begin
        e_ha[k] = m_g[0][0][k]; e_la[k] = m_g[0][1][k];
        e_hb[k] = m_g[1][0][k]; e_lb[k] = m_g[1][1][k];
      end
      vectors++;
      if ({gate_hi_a, gate_lo_a} !== {e_ha, e_la}) begin
        fails++;
        $display("FAIL R2 R3 R5 R6 R7 leg A t=%0t: hi/lo=%b/%b expected %b/%b",
                 $time, gate_hi_a, gate_lo_a, e_ha, e_la);
      end
      vectors++;
      if ({gate_hi_b, gate_lo_b} !== {e_hb, e_lb}) begin
        fails++;
        $display("FAIL R4 R5 R6 R7 leg B t=%0t: hi/lo=%b/%b expected %b/%b",
                 $time, gate_hi_b, gate_lo_b, e_hb, e_lb);
      end
      vectors++;
      if (((gate_hi_a & gate_lo_a) | (gate_hi_b & gate_lo_b)) != '0) begin
        fails++;
        $display("FAIL R8 overlap t=%0t: A %b/%b B %b/%b expected no common bit",
                 $time, gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected under 100000", cycles);
      finish_run();
    end
  end

  task automatic expect_off(string tag);
    vectors++;
    if ({gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b} != '0) begin
      fails++;
      $display("FAIL %s gates=%b expected all zero", tag,
               {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b});
    end
  endtask

  // R9: equal upper-gate on-time across cells over one full period
  task automatic duty_check(int r);
    int cnt_a[N];
    int cnt_b[N];
    int p;
    p = int'(period);
    ref_s = RW'(r);
    repeat (6 * p) @(negedge clk);
    for (int k = 0; k < N; k++) begin cnt_a[k] = 0; cnt_b[k] = 0; end
    repeat (2 * p) begin
      @(negedge clk);
      for (int k = 0; k < N; k++) begin
        cnt_a[k] += int'(gate_hi_a[k]);
        cnt_b[k] += int'(gate_hi_b[k]);
      end
    end
    for (int k = 1; k < N; k++) begin
      vectors++;
      if (cnt_a[k] != cnt_a[0] || cnt_b[k] != cnt_b[0]) begin
        fails++;
        $display("FAIL R9 ref=%0d cell %0d on-counts A=%0d B=%0d expected A=%0d B=%0d",
                 r, k, cnt_a[k], cnt_b[k], cnt_a[0], cnt_b[0]);
      end
    end
  endtask

  task automatic run_cfg(int p, int d);
    @(negedge clk);
    en = 1'b0;
    period = CW'(p);
    dead = DW'(d);
    @(negedge clk);
    expect_off("R1 disabled");
    en = 1'b1;
    // Full reference sweep, stride out of step with the carrier period (R5)
    for (int r = -(1 << (RW-1)); r < (1 << (RW-1)); r++) begin
      ref_s = RW'(r);
      repeat (7) @(negedge clk);
    end
    duty_check(45);
    duty_check(-90);
    duty_check(-(1 << (RW-1)));   // extreme code, R4 saturation on leg B
    // Drop enable mid-period: everything off one clock later (R1)
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    expect_off("R1 mid-run disable");
    en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_off("R1 in reset");
    rst = 1'b0;
    run_cfg(6, 2);   // 2P divisible by N
    run_cfg(5, 0);   // 2P not divisible by N, no dead time
    run_cfg(9, 4);   // longer dead time than short command pulses
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    expect_off("R1 reset while running");
    finish_run();
  end
endmodule